// File: doc/BRIEF.md
# Oversampling Nine-Bit Serial Receiver

This block takes in an asynchronous serial line and turns each 11-bit frame back into a byte and an extra ninth bit. A frame is a low start bit, eight data bits sent least significant bit first, a ninth bit and a stop bit. The line is resynchronized to the core clock and then looked at once per pulse of a tick input that runs at sixteen times the bit rate. A falling edge starts a frame and zeroes a 4-bit slice counter, which then marks out sixteen slices per bit. Each bit is taken as the majority of the line values seen at slices 8, 9 and 10.

A start bit that does not vote low is thrown away, and the receiver goes back to hunting for an edge. When the stop bit has been voted, the byte and the ninth bit are copied to the outputs and the receive flag is raised, but only if the flag is currently clear and the address filter is off or the ninth bit is 1. A filtered receiver therefore wakes only on frames whose ninth bit is 1. The flag stays high until the clear input is pulsed.

Top module: `serial9_rx`

## Requirements
- R1: After reset, rxFlag, rxData and rxBit9 are all 0.
- R2: A frame is a low start bit, data bits d0 first through d7, a ninth bit and a stop bit, each lasting 16 ticks. When it is accepted, rxData holds d7..d0 with d0 at bit 0, rxBit9 holds the ninth bit, and rxFlag rises in the clock cycle after the tick on which the stop bit is voted. rxData and rxBit9 change only in a cycle where rxFlag rises.
- R3: The slice counter is set to 0 on the tick that detects a falling edge and advances by one on every tick. Each bit is the 2-of-3 majority of the synchronized line at counter values 8, 9 and 10. One wrong sample does not change the bit, and two wrong samples do.
- R4: If the start bit votes high, the frame is abandoned with no change to the outputs, and the next falling edge starts a new frame.
- R5: While rxEnable is 0, nothing is received and rxFlag does not rise.
- R6: When addrFilter is 1, a frame whose ninth bit is 0 is discarded and rxFlag, rxData and rxBit9 keep their values. A frame whose ninth bit is 1 is accepted.
- R7: While rxFlag is 1, a newly completed frame is discarded and rxData and rxBit9 keep their values.
- R8: rxFlag stays 1 until clearFlag is sampled high, and it is 0 in the next cycle.
- R9: Edge hunting resumes once the stop bit has been voted, so a frame that starts right after the previous stop bit is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxIn | input | 1 | Serial line, idle high, asynchronous to clk |
| rxEnable | input | 1 | Receive enable |
| addrFilter | input | 1 | When 1, only frames with ninth bit 1 are accepted |
| tick16 | input | 1 | One-cycle pulse at sixteen times the bit rate |
| clearFlag | input | 1 | Clears rxFlag |
| rxData | output | 8 | Last accepted data byte |
| rxBit9 | output | 1 | Ninth bit of the last accepted frame |
| rxFlag | output | 1 | Frame-received flag |

## Verification
Plain frames with different byte values and both ninth-bit values check bit order and the placement of the ninth bit. Two frames sent back to back check that hunting restarts at the middle of the stop bit. Frames with one corrupted slice on every data bit, and with two corrupted slices on one bit, show whether a real majority is taken at the right three slices rather than a single sample. A short low pulse shows that a false start is rejected, and the valid frame that follows shows that hunting resumed. Frames sent with the filter on, with the flag still set, or with reception disabled separate the load conditions, because each of those frames must leave the outputs unchanged.

// File: rtl/serial9_pkg.sv
package serial9_pkg;
  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic capA;   // take first vote sample
    logic capB;   // take second vote sample
    logic shift;  // push voted bit into the shift register
    logic load;   // copy frame to the outputs and raise the flag
  } rxStrobe_t;
endpackage

// File: rtl/serial9_rx_ctrl.sv
module serial9_rx_ctrl
  import serial9_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  logic      rxEnable,
  input  logic      addrFilter,
  input  logic      fallEdge,
  input  logic      votedBit,
  input  logic      ninthBit,
  input  logic      flagBusy,
  output rxStrobe_t strb
);
  localparam int CNT_W    = $clog2(OVS);
  localparam int LAST_IDX = DATA_W + 2;
  localparam int IDX_W    = $clog2(LAST_IDX + 1);
  localparam logic [CNT_W-1:0] VOTE_A  = CNT_W'(OVS / 2);
  localparam logic [CNT_W-1:0] VOTE_B  = CNT_W'(OVS / 2 + 1);
  localparam logic [CNT_W-1:0] VOTE_C  = CNT_W'(OVS / 2 + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(LAST_IDX);

  typedef enum logic {HUNT, RECV} rxState_e;

  rxState_e         state;
  logic [CNT_W-1:0] sliceCnt;
  logic [IDX_W-1:0] bitIdx;
  logic             active;
  logic             decide;
  logic             isStart;
  logic             isLast;

  always_comb begin
    active     = (state == RECV) && rxEnable;
    decide     = active && tick && (sliceCnt == VOTE_C);
    isStart    = (bitIdx == '0);
    isLast     = (bitIdx == IDX_LAST);
    strb.capA  = active && tick && (sliceCnt == VOTE_A);
    strb.capB  = active && tick && (sliceCnt == VOTE_B);
    strb.shift = decide && !isStart && !isLast;
    strb.load  = decide && isLast && !flagBusy && (!addrFilter || ninthBit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= HUNT;
      sliceCnt <= '0;
      bitIdx   <= '0;
    end else if (!rxEnable) begin
      state <= HUNT;
    end else begin
      case (state)
        HUNT: begin
          if (tick && fallEdge) begin
            state    <= RECV;
            sliceCnt <= '0;
            bitIdx   <= '0;
          end
        end
        default: begin
          if (tick) begin
            sliceCnt <= (sliceCnt == CNT_MAX) ? '0 : sliceCnt + CNT_W'(1);
          end
          if (decide) begin
            if ((isStart && votedBit) || isLast) begin
              state <= HUNT;
            end else begin
              bitIdx <= bitIdx + IDX_W'(1);
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/serial9_rx_dp.sv
module serial9_rx_dp
  import serial9_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxIn,
  input  logic              tick,
  input  logic              clearFlag,
  input  rxStrobe_t         strb,
  output logic              fallEdge,
  output logic              votedBit,
  output logic              ninthBit,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit9,
  output logic              rxFlag
);
  localparam int SR_W = DATA_W + 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   lineNow;
  logic                   prevLevel;
  logic                   voteA;
  logic                   voteB;
  logic [SR_W-1:0]        shiftReg;

  // Synchronizer chain, idle level is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], rxIn};
  end

  assign lineNow  = syncQ[SYNC_STAGES-1];
  assign fallEdge = prevLevel && !lineNow;
  assign votedBit = (voteA & voteB) | (voteA & lineNow) | (voteB & lineNow);
  assign ninthBit = shiftReg[SR_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLevel <= 1'b1;
      voteA     <= 1'b1;
      voteB     <= 1'b1;
      shiftReg  <= '0;
    end else begin
      if (tick)       prevLevel <= lineNow;
      if (strb.capA)  voteA     <= lineNow;
      if (strb.capB)  voteB     <= lineNow;
      if (strb.shift) shiftReg  <= {votedBit, shiftReg[SR_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData <= '0;
      rxBit9 <= 1'b0;
      rxFlag <= 1'b0;
    end else begin
      if (strb.load) begin
        rxData <= shiftReg[DATA_W-1:0];
        rxBit9 <= shiftReg[SR_W-1];
        rxFlag <= 1'b1;
      end else if (clearFlag) begin
        rxFlag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/serial9_rx.sv
module serial9_rx
  import serial9_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxIn,
  input  logic              rxEnable,
  input  logic              addrFilter,
  input  logic              tick16,
  input  logic              clearFlag,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit9,
  output logic              rxFlag
);
  rxStrobe_t strb;
  logic      fallEdge;
  logic      votedBit;
  logic      ninthBit;

  serial9_rx_ctrl #(.OVS(OVS), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick16), .rxEnable(rxEnable),
    .addrFilter(addrFilter), .fallEdge(fallEdge), .votedBit(votedBit),
    .ninthBit(ninthBit), .flagBusy(rxFlag), .strb(strb)
  );

  serial9_rx_dp #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .tick(tick16), .clearFlag(clearFlag),
    .strb(strb), .fallEdge(fallEdge), .votedBit(votedBit), .ninthBit(ninthBit),
    .rxData(rxData), .rxBit9(rxBit9), .rxFlag(rxFlag)
  );
endmodule

// File: rtl/serial9_rx_chk.sv
module serial9_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxEnable,
  input logic              addrFilter,
  input logic              clearFlag,
  input logic [DATA_W-1:0] rxData,
  input logic              rxBit9,
  input logic              rxFlag
);
  // R2: outputs change only together with a rising flag
  a_r2_update_with_flag: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({rxData, rxBit9}) |-> $rose(rxFlag));

  // R5: no frame is accepted while reception is disabled
  a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEnable && !rxFlag) |=> !rxFlag);

  // R6: with the filter on, an accepted frame carries ninth bit 1
  a_r6_filter_gate: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rxFlag) && $past(addrFilter)) |-> rxBit9);

  // R7: a pending flag protects the buffer
  a_r7_no_overwrite: assert property (@(posedge clk) disable iff (!rstN)
    rxFlag |=> ($stable(rxData) && $stable(rxBit9)));

  // R8: flag holds until cleared
  a_r8_flag_holds: assert property (@(posedge clk) disable iff (!rstN)
    (rxFlag && !clearFlag) |=> rxFlag);

  // R8: clear takes effect the next cycle
  a_r8_flag_clears: assert property (@(posedge clk) disable iff (!rstN)
    (rxFlag && clearFlag) |=> !rxFlag);
endmodule

bind serial9_rx serial9_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .addrFilter(addrFilter),
  .clearFlag(clearFlag), .rxData(rxData), .rxBit9(rxBit9), .rxFlag(rxFlag)
);

// File: tb/sim_serial9_rx.sv
`timescale 1ns/1ps
module sim_serial9_rx;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxIn = 1'b1;
  logic       rxEnable = 1'b1;
  logic       addrFilter = 1'b0;
  logic       tick16 = 1'b0;
  logic       clearFlag = 1'b0;
  logic [7:0] rxData;
  logic       rxBit9;
  logic       rxFlag;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit riModel = 0;
  bit flagSeen = 0;
  logic [8:0] expQ[$];

  always #5 clk = ~clk;

  serial9_rx u0 (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .rxEnable(rxEnable),
    .addrFilter(addrFilter), .tick16(tick16), .clearFlag(clearFlag),
    .rxData(rxData), .rxBit9(rxBit9), .rxFlag(rxFlag)
  );

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One tick period is four clocks, the tick seen on one rising edge
  task automatic stepTick();
    @(negedge clk); tick16 = 1'b1;
    @(negedge clk); tick16 = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic sendBit(input logic b, input int gA, input int gB);
    for (int t = 0; t < 16; t++) begin
      rxIn = (t == gA || t == gB) ? ~b : b;
      stepTick();
    end
  endtask

  task automatic clearRi();
    @(negedge clk); clearFlag = 1'b1;
    @(negedge clk); clearFlag = 1'b0;
    riModel = 0;
  endtask

  // Driver: predicts acceptance and queues the expected result
  task automatic sendFrame(input logic [7:0] data, input logic ninth,
                           input logic [7:0] expData, input logic [10:0] glitchMask,
                           input int gA, input int gB);
    logic [10:0] bits;
    bits = {1'b1, ninth, data, 1'b0};
    if (rxEnable && !riModel && (!addrFilter || ninth)) begin
      expQ.push_back({ninth, expData});
      riModel = 1;
    end
    for (int i = 0; i < 11; i++) begin
      if (glitchMask[i]) sendBit(bits[i], gA, gB);
      else               sendBit(bits[i], -1, -1);
    end
    rxIn = 1'b1;
  endtask

  task automatic idleTicks(input int n);
    rxIn = 1'b1;
    for (int i = 0; i < n; i++) stepTick();
  endtask

  // Monitor: compare each rising flag against the queue
  always @(negedge clk) begin
    if (rstN && rxFlag && !flagSeen) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: actual flag rise with %0h expected none", {rxBit9, rxData});
      end else begin
        logic [8:0] e;
        e = expQ.pop_front();
        checkEq("R2 frame contents", {23'd0, rxBit9, rxData}, {23'd0, e});
      end
    end
    flagSeen = rxFlag;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkEq("R1 flag", {31'd0, rxFlag}, 32'd0);
    checkEq("R1 data", {24'd0, rxData}, 32'd0);
    checkEq("R1 bit9", {31'd0, rxBit9}, 32'd0);
    rstN = 1'b1;
    idleTicks(4);

    // R2: plain frames
    sendFrame(8'h5A, 1'b0, 8'h5A, 11'd0, -1, -1);
    idleTicks(2);
    clearRi();
    checkEq("R8 flag cleared", {31'd0, rxFlag}, 32'd0);
    sendFrame(8'hA5, 1'b1, 8'hA5, 11'd0, -1, -1);
    idleTicks(2);
    clearRi();

    // R9: back to back frames, clear at each frame start
    sendFrame(8'h3C, 1'b0, 8'h3C, 11'd0, -1, -1);
    clearRi();
    sendFrame(8'hC3, 1'b1, 8'hC3, 11'd0, -1, -1);
    clearRi();

    // R3: one bad slice per data bit leaves bits intact
    sendFrame(8'h96, 1'b0, 8'h96, 11'b00111111110, 9, -1);
    idleTicks(2);
    clearRi();
    // R3: two bad slices on d0 flip it
    sendFrame(8'h96, 1'b0, 8'h97, 11'b00000000010, 9, 10);
    idleTicks(2);
    clearRi();

    // R4: false start, then a good frame
    for (int t = 0; t < 16; t++) begin
      rxIn = (t < 6) ? 1'b0 : 1'b1;
      stepTick();
    end
    idleTicks(20);
    checkEq("R4 no flag after false start", {31'd0, rxFlag}, 32'd0);
    checkEq("R4 data kept", {24'd0, rxData}, 32'h97);
    sendFrame(8'h21, 1'b0, 8'h21, 11'd0, -1, -1);
    idleTicks(2);
    clearRi();

    // R6: filter on
    addrFilter = 1'b1;
    sendFrame(8'h44, 1'b0, 8'h44, 11'd0, -1, -1);
    idleTicks(2);
    checkEq("R6 flag stays low", {31'd0, rxFlag}, 32'd0);
    checkEq("R6 data kept", {24'd0, rxData}, 32'h21);
    sendFrame(8'h88, 1'b1, 8'h88, 11'd0, -1, -1);
    idleTicks(2);
    addrFilter = 1'b0;

    // R7: flag still set, new frame discarded
    sendFrame(8'h11, 1'b0, 8'h11, 11'd0, -1, -1);
    idleTicks(2);
    checkEq("R7 flag held", {31'd0, rxFlag}, 32'd1);
    checkEq("R7 data kept", {24'd0, rxData}, 32'h88);
    checkEq("R7 bit9 kept", {31'd0, rxBit9}, 32'd1);
    clearRi();
    checkEq("R8 flag cleared again", {31'd0, rxFlag}, 32'd0);

    // R5: disabled
    rxEnable = 1'b0;
    sendFrame(8'h77, 1'b1, 8'h77, 11'd0, -1, -1);
    idleTicks(2);
    checkEq("R5 no flag", {31'd0, rxFlag}, 32'd0);
    checkEq("R5 data kept", {24'd0, rxData}, 32'h88);
    rxEnable = 1'b1;
    idleTicks(4);

    checkEq("R2 all expected frames seen", expQ.size(), 32'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule